// File: doc/BRIEF.md
# Pad Tower Coincidence Trigger

This block makes the pad-level trigger decision for one detector sector. Eight layers of pads deliver one hit bit per pad each bunch crossing. The layers form two groups of four. Odd-numbered layers are shifted by half a pad against even-numbered layers, so the half-pad cells where the staggered boundaries overlap form a row of logical towers. Each layer input first passes through its own programmable delay, so that layers arriving with different latencies line up on the same crossing.

A tower fires when at least three of the four layers in each group cover it in the aligned crossing. The lowest-numbered firing tower is reported as a binary band index with a valid strobe. That index selects the single strip band that is pulled from the strip pipeline held elsewhere. A separate flag marks crossings in which more than one tower fired. One result is produced every cycle, one clock after the aligned inputs.

Top module: `ptc_pad_trigger`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `trig_valid`, `band_idx` and `multi_cand` are all zero.
- R2: Layers 0..3 form group A and layers 4..7 form group B. Layer l uses bits `pad_hits[l*NUM_PADS +: NUM_PADS]`. There are 2*NUM_PADS-1 towers. Tower b is covered by pad (b+1)/2 (rounded down) of every even layer and by pad b/2 (rounded down) of every odd layer.
- R3: A group counts a tower only when at least 3 of its 4 aligned layers cover it. Two or fewer covering layers never contribute.
- R4: A tower fires only when both group A and group B count it in the same aligned crossing.
- R5: When at least one tower fires, `trig_valid` is 1 and `band_idx` holds the lowest firing tower number in plain binary.
- R6: `multi_cand` is 1 exactly when two or more towers fire in the same crossing. It is never 1 without `trig_valid`.
- R7: When no tower fires, `trig_valid`, `band_idx` and `multi_cand` are all 0.
- R8: Layer l is delayed by the value in `dly_cfg[l*DLY_W +: DLY_W]`, from 0 to MAX_DLY cycles, before the coincidence is formed. The result appears one clock after the aligned crossing, so the total latency is delay+1 cycles. A delay that changes takes effect at once, because the delay line keeps shifting whatever the setting.
- R9: Every cycle yields an independent result, so back-to-back crossings do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_hits | input | 8*NUM_PADS | Pad hit bits, layer l at l*NUM_PADS |
| dly_cfg | input | 8*DLY_W | Per-layer alignment delay, layer l at l*DLY_W |
| trig_valid | output | 1 | At least one tower fired |
| band_idx | output | IDX_W | Lowest firing tower number |
| multi_cand | output | 1 | More than one tower fired |

## Verification
The checker's input-side properties assume that a zero delay setting means an input reaches the coincidence in the same cycle. From that they conclude that an empty group B, or two empty layers in group A, rules out a trigger one clock later. These properties are only meaningful when all delays are zero, so each one is guarded on `dly_cfg` being zero. The stimulus reaches non-zero delays only after reset has cleared the delay lines. Because the delay lines keep shifting whatever the setting, the bench can change delays on any cycle: its history model tracks the last MAX_DLY crossings of every layer, so every setting stays consistent with it.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    localparam int NUM_GROUPS       = 2;
    localparam int LAYERS_PER_GROUP = 4;
    localparam int NUM_LAYERS       = NUM_GROUPS * LAYERS_PER_GROUP;
    localparam int MAJORITY_MIN     = 3;

    function automatic logic group_majority(input logic [LAYERS_PER_GROUP-1:0] cov);
        int n;
        n = 0;
        for (int i = 0; i < LAYERS_PER_GROUP; i++) begin
            n += int'(cov[i]);
        end
        return n >= MAJORITY_MIN;
    endfunction
endpackage

// File: rtl/ptc_deskew.sv
module ptc_deskew #(
    parameter int NUM_PADS = 4,
    parameter int MAX_DLY  = 3,
    parameter int DLY_W    = (MAX_DLY > 0) ? $clog2(MAX_DLY + 1) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] hits_in,
    input  logic [DLY_W-1:0]    dly,
    output logic [NUM_PADS-1:0] hits_out
);
    localparam int DEPTH = (MAX_DLY > 0) ? MAX_DLY : 1;

    logic [DEPTH-1:0][NUM_PADS-1:0] line_d, line_q;

    always_comb begin
        line_d[0] = hits_in;
        for (int k = 1; k < DEPTH; k++) begin
            line_d[k] = line_q[k-1];
        end
        hits_out = hits_in;
        for (int k = 1; k <= MAX_DLY; k++) begin
            if (int'(dly) == k) begin
                hits_out = line_q[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end
endmodule

// File: rtl/ptc_tower_map.sv
module ptc_tower_map
    import ptc_pkg::*;
#(
    parameter int NUM_PADS   = 4,
    parameter int NUM_TOWERS = 2 * NUM_PADS - 1
) (
    input  logic [LAYERS_PER_GROUP-1:0][NUM_PADS-1:0] grp_hits,
    output logic [NUM_TOWERS-1:0]                      grp_fire
);
    genvar b;
    generate
        for (b = 0; b < NUM_TOWERS; b++) begin : g_tower
            localparam int PAD_EVEN = (b + 1) / 2;
            localparam int PAD_ODD  = b / 2;
            logic [LAYERS_PER_GROUP-1:0] cov;
            always_comb begin
                for (int l = 0; l < LAYERS_PER_GROUP; l++) begin
                    cov[l] = (l % 2 == 0) ? grp_hits[l][PAD_EVEN] : grp_hits[l][PAD_ODD];
                end
            end
            assign grp_fire[b] = group_majority(cov);
        end
    endgenerate
endmodule

// File: rtl/ptc_pick.sv
module ptc_pick #(
    parameter int NUM_TOWERS = 7,
    parameter int IDX_W      = (NUM_TOWERS > 1) ? $clog2(NUM_TOWERS) : 1
) (
    input  logic [NUM_TOWERS-1:0] fire,
    output logic                  any_fire,
    output logic [IDX_W-1:0]      first_idx,
    output logic                  several
);
    always_comb begin
        first_idx = '0;
        for (int t = NUM_TOWERS - 1; t >= 0; t--) begin
            if (fire[t]) begin
                first_idx = IDX_W'(t);
            end
        end
        any_fire = |fire;
        several  = |(fire & (fire - 1'b1));
    end
endmodule

// File: rtl/ptc_pad_trigger.sv
module ptc_pad_trigger
    import ptc_pkg::*;
#(
    parameter int NUM_PADS   = 4,
    parameter int MAX_DLY    = 3,
    parameter int DLY_W      = (MAX_DLY > 0) ? $clog2(MAX_DLY + 1) : 1,
    parameter int NUM_TOWERS = 2 * NUM_PADS - 1,
    parameter int IDX_W      = (NUM_TOWERS > 1) ? $clog2(NUM_TOWERS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LAYERS*NUM_PADS-1:0] pad_hits,
    input  logic [NUM_LAYERS*DLY_W-1:0]    dly_cfg,
    output logic                           trig_valid,
    output logic [IDX_W-1:0]               band_idx,
    output logic                           multi_cand
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] band;
        logic             multi;
    } result_t;

    logic [NUM_GROUPS-1:0][LAYERS_PER_GROUP-1:0][NUM_PADS-1:0] aligned;
    logic [NUM_GROUPS-1:0][NUM_TOWERS-1:0]                     grp_fire;
    logic [NUM_TOWERS-1:0] tower_fire;
    logic                  any_fire, several;
    logic [IDX_W-1:0]      first_idx;
    result_t               res_d, res_q;

    genvar g, l;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
            for (l = 0; l < LAYERS_PER_GROUP; l++) begin : g_lyr
                localparam int LI = g * LAYERS_PER_GROUP + l;
                ptc_deskew #(
                    .NUM_PADS(NUM_PADS),
                    .MAX_DLY (MAX_DLY),
                    .DLY_W   (DLY_W)
                ) u_dsk (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .hits_in (pad_hits[LI*NUM_PADS +: NUM_PADS]),
                    .dly     (dly_cfg[LI*DLY_W +: DLY_W]),
                    .hits_out(aligned[g][l])
                );
            end
            ptc_tower_map #(
                .NUM_PADS  (NUM_PADS),
                .NUM_TOWERS(NUM_TOWERS)
            ) u_map (
                .grp_hits(aligned[g]),
                .grp_fire(grp_fire[g])
            );
        end
    endgenerate

    always_comb begin
        tower_fire = '1;
        for (int k = 0; k < NUM_GROUPS; k++) begin
            tower_fire &= grp_fire[k];
        end
    end

    ptc_pick #(
        .NUM_TOWERS(NUM_TOWERS),
        .IDX_W     (IDX_W)
    ) u_pick (
        .fire     (tower_fire),
        .any_fire (any_fire),
        .first_idx(first_idx),
        .several  (several)
    );

    always_comb begin
        res_d.valid = any_fire;
        res_d.band  = any_fire ? first_idx : '0;
        res_d.multi = any_fire & several;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign trig_valid = res_q.valid;
    assign band_idx   = res_q.band;
    assign multi_cand = res_q.multi;
endmodule

// File: rtl/ptc_pad_trigger_chk.sv
module ptc_pad_trigger_chk
    import ptc_pkg::*;
#(
    parameter int NUM_PADS   = 4,
    parameter int DLY_W      = 2,
    parameter int NUM_TOWERS = 2 * NUM_PADS - 1,
    parameter int IDX_W      = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_LAYERS*NUM_PADS-1:0] pad_hits,
    input logic [NUM_LAYERS*DLY_W-1:0]    dly_cfg,
    input logic                           trig_valid,
    input logic [IDX_W-1:0]               band_idx,
    input logic                           multi_cand
);
    localparam int HALF = LAYERS_PER_GROUP * NUM_PADS;

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_valid |-> (band_idx == '0 && !multi_cand));

    a_r6_multi_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        multi_cand |-> trig_valid);

    a_r5_band_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> (int'(band_idx) < NUM_TOWERS));

    a_r4_empty_group_b_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_cfg == '0 && pad_hits[2*HALF-1:HALF] == '0) |=> !trig_valid);

    a_r3_two_dead_layers_block: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_cfg == '0 && pad_hits[2*NUM_PADS-1:0] == '0) |=> !trig_valid);
endmodule

bind ptc_pad_trigger ptc_pad_trigger_chk #(
    .NUM_PADS  (NUM_PADS),
    .DLY_W     (DLY_W),
    .NUM_TOWERS(NUM_TOWERS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_hits  (pad_hits),
    .dly_cfg   (dly_cfg),
    .trig_valid(trig_valid),
    .band_idx  (band_idx),
    .multi_cand(multi_cand)
);

// File: tb/ptc_pad_trigger_tb.sv
module ptc_pad_trigger_tb;
    localparam int NP = 4;
    localparam int NL = 8;
    localparam int MD = 3;
    localparam int DW = 2;
    localparam int NT = 2 * NP - 1;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic [NL*NP-1:0] pad_hits;
    logic [NL*DW-1:0] dly_cfg;
    logic             trig_valid;
    logic [IW-1:0]    band_idx;
    logic             multi_cand;

    ptc_pad_trigger #(.NUM_PADS(NP), .MAX_DLY(MD)) u_dut (
        .clk(clk), .rst_n(rst_n), .pad_hits(pad_hits), .dly_cfg(dly_cfg),
        .trig_valid(trig_valid), .band_idx(band_idx), .multi_cand(multi_cand)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [NP-1:0] hist [0:MD][0:NL-1];
    bit    pend = 1'b0;
    bit    e_v, e_m;
    int    e_b;
    string e_req;

    function automatic void model(input logic [NL*DW-1:0] cfg,
                                  output bit v, output int b, output bit m);
        int nfire;
        v = 1'b0; b = 0; m = 1'b0; nfire = 0;
        for (int t = 0; t < NT; t++) begin
            int ca, cb;
            ca = 0; cb = 0;
            for (int l = 0; l < NL; l++) begin
                logic [NP-1:0] w;
                bit cov;
                w = hist[int'(cfg[l*DW +: DW])][l];
                cov = 1'b0;
                for (int p = 0; p < NP; p++) begin
                    if (w[p]) begin
                        if (l % 2 == 0 && (t == 2*p - 1 || t == 2*p)) cov = 1'b1;
                        if (l % 2 == 1 && (t == 2*p || t == 2*p + 1)) cov = 1'b1;
                    end
                end
                if (cov) begin
                    if (l < 4) ca++; else cb++;
                end
            end
            if (ca >= 3 && cb >= 3) begin
                if (nfire == 0) b = t;
                nfire++;
            end
        end
        v = (nfire > 0);
        m = (nfire > 1);
    endfunction

    function automatic logic [NL*NP-1:0] band_pat(input int b, input bit [3:0] ma, input bit [3:0] mb);
        logic [NL*NP-1:0] r;
        r = '0;
        for (int l = 0; l < NL; l++) begin
            bit present;
            int pad;
            present = (l < 4) ? ma[l] : mb[l-4];
            pad = (l % 2 == 0) ? (b + 1) / 2 : b / 2;
            if (present) r[l*NP + pad] = 1'b1;
        end
        return r;
    endfunction

    task automatic compare();
        total++;
        if (trig_valid !== e_v || int'(band_idx) != e_b || multi_cand !== e_m) begin
            bad++;
            $display("FAIL %s: valid=%0d band=%0d multi=%0d expected valid=%0d band=%0d multi=%0d",
                     e_req, trig_valid, band_idx, multi_cand, e_v, e_b, e_m);
        end
    endtask

    task automatic step(input logic [NL*NP-1:0] h, input logic [NL*DW-1:0] c, input string req);
        @(negedge clk);
        if (pend) compare();
        pad_hits = h;
        dly_cfg  = c;
        for (int k = MD; k > 0; k--) begin
            for (int l = 0; l < NL; l++) hist[k][l] = hist[k-1][l];
        end
        for (int l = 0; l < NL; l++) hist[0][l] = h[l*NP +: NP];
        model(c, e_v, e_b, e_m);
        e_req = req;
        pend = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [NL*DW-1:0] cfg;
        rst_n = 1'b0;
        pad_hits = '0;
        dly_cfg = '0;
        for (int k = 0; k <= MD; k++)
            for (int l = 0; l < NL; l++) hist[k][l] = '0;

        // R1: reset state, held inputs full so a live design would fire
        pad_hits = band_pat(2, 4'hF, 4'hF);
        repeat (3) begin
            @(negedge clk);
            total++;
            if (trig_valid !== 1'b0 || band_idx !== '0 || multi_cand !== 1'b0) begin
                bad++;
                $display("FAIL R1: valid=%0d band=%0d multi=%0d expected 0 0 0",
                         trig_valid, band_idx, multi_cand);
            end
        end
        pad_hits = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (trig_valid !== 1'b0 || band_idx !== '0 || multi_cand !== 1'b0) begin
            bad++;
            $display("FAIL R1 first cycle: valid=%0d band=%0d multi=%0d expected 0 0 0",
                     trig_valid, band_idx, multi_cand);
        end

        // R2 / R5: edge towers
        step(band_pat(0, 4'hF, 4'hF), '0, "R2");
        step(band_pat(NT-1, 4'hF, 4'hF), '0, "R5");
        step(band_pat(3, 4'b0111, 4'b1110), '0, "R2");
        // R3: two layers in group A only
        step(band_pat(3, 4'b0011, 4'hF), '0, "R3");
        // R4: group B empty
        step(band_pat(3, 4'hF, 4'h0), '0, "R4");
        // R6: two towers fire
        step(band_pat(1, 4'hF, 4'hF) | band_pat(4, 4'hF, 4'hF), '0, "R6");
        // R7: nothing
        step('0, '0, "R7");
        step('1, '0, "R6");

        // R3 / R4: exhaustive per tower over group layer masks
        for (int b = 0; b < NT; b++)
            for (int ma = 0; ma < 16; ma++)
                for (int mb = 0; mb < 16; mb++)
                    step(band_pat(b, 4'(ma), 4'(mb)), '0, "R3");

        // R5 / R6: random sparse patterns, zero delay
        for (int i = 0; i < 1500; i++)
            step(NL*NP'($urandom & $urandom), '0, "R6");

        // R8: directed alignment, layer l delayed by l%4, band 2 driven early
        cfg = '0;
        for (int l = 0; l < NL; l++) cfg[l*DW +: DW] = DW'(l % 4);
        for (int k = 0; k <= MD; k++) begin
            logic [NL*NP-1:0] h;
            h = '0;
            for (int l = 0; l < NL; l++)
                if (l % 4 == MD - k) h[l*NP +: NP] = band_pat(2, 4'hF, 4'hF) >> (l*NP);
            step(h & band_pat(2, 4'hF, 4'hF), cfg, "R8");
        end
        step('0, cfg, "R8");
        step('0, cfg, "R8");

        // R8: random delays changing every cycle
        for (int i = 0; i < 3000; i++)
            step(NL*NP'($urandom | $urandom), NL*DW'($urandom), "R8");

        // R9: back-to-back alternation
        for (int i = 0; i < 200; i++)
            step((i % 2 == 0) ? band_pat(i % NT, 4'hF, 4'hF) : '0, '0, "R9");

        @(negedge clk);
        if (pend) compare();
        pend = 1'b0;
        finish_run();
    end
endmodule